// File: doc/BRIEF.md
# Serial-Addressed Wiper Register Bank

This block is the digital core of a multi-channel digital potentiometer. A three-wire serial port (active-low select, serial clock, serial data) feeds an 11-bit shift register. Each frame has a 3-bit channel address in front of an 8-bit wiper code. When the select line goes high again, the block decodes the address and writes the code into that channel's wiper register. The resistor network reads these 8-bit codes. All serial and control pins are sampled in the system clock domain through two-flop synchronisers, and edges are detected on the synchronised copies.

The far end of the shift register drives a serial output, so several parts can be cascaded on one select line. A held-low preset input and the system reset both put every wiper at midscale. A shutdown input is synchronised and passed out as a per-bank shutdown flag. It leaves the stored codes untouched.

Top module: `wiper_bank`

## Requirements
- R1: A frame is shifted in MSB first. After the last clock, shift register bits [10:8] hold the channel address and bits [7:0] hold the wiper code.
- R2: A shift happens only on a synchronised rising edge of `ser_clk` while `ser_cs_n` is low. Serial clock edges while `ser_cs_n` is high leave the shift register unchanged.
- R3: Wiper registers change only after a rising edge of `ser_cs_n`. No wiper changes while the select is low, and the new code is visible at most 4 system clocks after the rise.
- R4: Address value n, for n below NUM_CH, writes channel n only. Channel n occupies `wiper_code[8n+7:8n]`. At most one channel is written per commit.
- R5: A commit whose address is NUM_CH or higher (6 and 7 by default) writes no channel.
- R6: After reset every wiper reads 0x80, `ser_dout` is 0 and `shutdown_n` is 1.
- R7: While `preset_n` is low, every wiper is forced to 0x80 and any commit is discarded. The stored codes stay at 0x80 after `preset_n` returns high.
- R8: `ser_dout` equals shift register bit 10, so a bit shifted in comes out 11 shifts later. `ser_dout_pull` is its inverse and is the enable for an open-drain pull-down.
- R9: `shutdown_n` follows `shdn_n` after synchronisation, and the wiper codes do not change because of it.
- R10: If the number of serial clocks in a frame is not 11, the commit decodes the 11 most recent bits in the shift register. Older bits pushed out early are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_cs_n | input | 1 | Serial select, active low; its rising edge commits the frame |
| ser_clk | input | 1 | Serial shift clock, rising edge active |
| ser_din | input | 1 | Serial data in, MSB first |
| preset_n | input | 1 | Active-low force of all wipers to midscale |
| shdn_n | input | 1 | Active-low shutdown request |
| ser_dout | output | 1 | Far end of the shift register, plain logic view |
| ser_dout_pull | output | 1 | Open-drain pull-down enable (1 = drive low) |
| shutdown_n | output | 1 | Synchronised shutdown flag, active low |
| wiper_code | output | NUM_CH*8 | Concatenated wiper codes, channel 0 in the low byte |

## Verification
The assertions assume that each serial input level lasts at least three system clocks. Under that condition the synchronisers see every edge exactly once and the data bit is stable when the clock edge is detected. The assertions also assume that `rst_n` is deasserted synchronously. The stimulus meets this by holding each serial clock phase, each data bit and each select level for four system clocks. It also waits several clocks after every preset or shutdown change before it sends the next event.

// File: rtl/wbank_pkg.sv
package wbank_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] code_t;
  typedef logic [FRAME_W-1:0] frame_t;
endpackage

// File: rtl/wbank_sync.sv
module wbank_sync #(
  parameter int            WIDTH   = 1,
  parameter int            STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/wbank_shifter.sv
module wbank_shifter
  import wbank_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cs_n_s,
  input  logic   sclk_s,
  input  logic   din_s,
  output frame_t frame_o,
  output logic   commit_o,
  output logic   sdo_o
);
  logic   cs_prev_q, sclk_prev_q;
  frame_t sr_q, sr_d;
  logic   shift_en;

  assign shift_en = sclk_s & ~sclk_prev_q & ~cs_n_s;
  assign commit_o = cs_n_s & ~cs_prev_q;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {sr_q[FRAME_W-2:0], din_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
      sr_q        <= '0;
    end else begin
      cs_prev_q   <= cs_n_s;
      sclk_prev_q <= sclk_s;
      sr_q        <= sr_d;
    end
  end

  assign frame_o = sr_q;
  assign sdo_o   = sr_q[FRAME_W-1];

  // R2: with select high, serial clock activity does not move the register
  assert_no_shift_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> $stable(sr_q));
  // R8: serial output moves only after a detected shift
  assert_dout_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_s && !sclk_prev_q && !cs_n_s) |=> $stable(sdo_o));
endmodule

// File: rtl/wbank_latches.sv
module wbank_latches
  import wbank_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     preset_n_s,
  input  logic                     commit,
  input  frame_t                   frame,
  output logic [NUM_CH*DATA_W-1:0] wipers_o
);
  addr_t             addr;
  code_t             data;
  logic [NUM_CH-1:0] wr_en;
  logic              addr_ok;

  assign addr    = frame[FRAME_W-1:DATA_W];
  assign data    = frame[DATA_W-1:0];
  assign addr_ok = int'(addr) < NUM_CH;

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      code_t code_q, code_d;
      assign wr_en[ch] = commit && (addr == ADDR_W'(ch));

      always_comb begin
        code_d = code_q;
        if (!preset_n_s)    code_d = MID_CODE;
        else if (wr_en[ch]) code_d = data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= MID_CODE;
        else        code_q <= code_d;
      end

      assign wipers_o[ch*DATA_W +: DATA_W] = code_q;

      // R7: preset leaves every channel at midscale on the next cycle
      assert_preset_mid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !preset_n_s |=> (code_q == MID_CODE));
    end
  endgenerate

  // R4: a commit targets at most one channel
  assert_single_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));
  // R5: out-of-range address leaves all codes untouched
  assert_bad_addr_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !addr_ok && preset_n_s) |=> $stable(wipers_o));
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
  import wbank_pkg::*;
#(
  parameter int NUM_CH      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ser_cs_n,
  input  logic                     ser_clk,
  input  logic                     ser_din,
  input  logic                     preset_n,
  input  logic                     shdn_n,
  output logic                     ser_dout,
  output logic                     ser_dout_pull,
  output logic                     shutdown_n,
  output logic [NUM_CH*DATA_W-1:0] wiper_code
);
  localparam int NUM_IN = 5;
  localparam logic [NUM_IN-1:0] IN_RST = 5'b11001;

  logic [NUM_IN-1:0] raw_in, syn_in;
  logic   cs_n_s, sclk_s, din_s, preset_n_s, shdn_n_s;
  frame_t frame;
  logic   commit;

  assign raw_in = {ser_cs_n, shdn_n, preset_n, ser_clk, ser_din};
  assign {cs_n_s, shdn_n_s, preset_n_s, sclk_s, din_s} = syn_in;

  wbank_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(syn_in));

  wbank_shifter shift_i (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sclk_s(sclk_s), .din_s(din_s),
    .frame_o(frame), .commit_o(commit), .sdo_o(ser_dout));

  wbank_latches #(.NUM_CH(NUM_CH)) lat_i (
    .clk(clk), .rst_n(rst_n), .preset_n_s(preset_n_s), .commit(commit),
    .frame(frame), .wipers_o(wiper_code));

  assign ser_dout_pull = ~ser_dout;
  assign shutdown_n    = shdn_n_s;

  // R3: no wiper moves while the synchronised select is low (preset aside)
  assert_hold_while_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_s && preset_n_s) |=> $stable(wiper_code));
  // R9: a shutdown change alone never disturbs the codes
  assert_shutdown_keeps_codes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_n_s != $past(shdn_n_s) && !commit && preset_n_s) |=> $stable(wiper_code));
endmodule

// File: tb/wiper_bank_tb.sv
module wiper_bank_tb_top;
  localparam int NCH = 6;
  localparam int W   = NCH * 8;

  logic clk = 1'b0;
  logic rst_n, ser_cs_n, ser_clk, ser_din, preset_n, shdn_n;
  logic ser_dout, ser_dout_pull, shutdown_n;
  logic [W-1:0] wiper_code;

  always #2 clk = ~clk;

  wiper_bank #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk),
    .ser_din(ser_din), .preset_n(preset_n), .shdn_n(shdn_n),
    .ser_dout(ser_dout), .ser_dout_pull(ser_dout_pull),
    .shutdown_n(shutdown_n), .wiper_code(wiper_code));

  typedef struct { string tag; logic [W-1:0] vec; } exp_t;
  exp_t exp_q[$];

  int checks = 0, errors = 0;
  logic [10:0] m_sr;
  logic [7:0]  m_lat [NCH];
  bit          m_preset_n;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_vec();
    logic [W-1:0] v;
    for (int c = 0; c < NCH; c++) v[c*8 +: 8] = m_lat[c];
    return v;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push_exp(input string tag);
    exp_t e;
    e.tag = tag;
    e.vec = model_vec();
    exp_q.push_back(e);
  endtask

  // monitor: compare queued expectations against the wiper outputs
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(wiper_code === e.vec, e.tag, 64'(wiper_code), 64'(e.vec));
      end
    end
  end

  // R8: before each rise the output shows bit 10 of the model register
  task automatic sbit(input logic b, input bit shift_it);
    ser_din = b;
    wait_clk(4);
    check(ser_dout === m_sr[10] && ser_dout_pull === ~m_sr[10], "R8 serial out",
          64'({ser_dout, ser_dout_pull}), 64'({m_sr[10], ~m_sr[10]}));
    ser_clk = 1'b1;
    if (shift_it) m_sr = {m_sr[9:0], b};
    wait_clk(4);
    ser_clk = 1'b0;
  endtask

  task automatic cs_rise(input string tag);
    ser_cs_n = 1'b1;
    if (!m_preset_n) begin
      for (int c = 0; c < NCH; c++) m_lat[c] = 8'h80;
    end else if (int'(m_sr[10:8]) < NCH) begin
      m_lat[m_sr[10:8]] = m_sr[7:0];
    end
    wait_clk(4);
    push_exp(tag);
    wait_clk(4);
  endtask

  task automatic send(input logic [31:0] bits, input int n, input string tag);
    ser_cs_n = 1'b0;
    wait_clk(4);
    for (int i = n - 1; i >= 0; i--) sbit(bits[i], 1'b1);
    wait_clk(2);
    // R3: nothing committed while the select is still low
    push_exp({tag, " R3 hold"});
    wait_clk(2);
    cs_rise(tag);
  endtask

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ser_cs_n = 1'b1; ser_clk = 1'b0; ser_din = 1'b0;
    preset_n = 1'b1; shdn_n = 1'b1;
    m_sr = '0; m_preset_n = 1'b1;
    for (int c = 0; c < NCH; c++) m_lat[c] = 8'h80;
    wait_clk(3);
    #1 rst_n = 1'b1;
    wait_clk(4);
    // R6: reset state
    push_exp("R6 reset wipers");
    check(ser_dout === 1'b0 && ser_dout_pull === 1'b1 && shutdown_n === 1'b1, "R6 reset pins",
          64'({ser_dout, ser_dout_pull, shutdown_n}), 64'(3'b011));
    wait_clk(2);

    // R1 / R4: addressed writes, MSB first
    send({21'd0, 3'd0, 8'h3C}, 11, "R1 ch0 write");
    send({21'd0, 3'd5, 8'hFF}, 11, "R4 ch5 write");
    send({21'd0, 3'd3, 8'h00}, 11, "R4 ch3 write");
    send({21'd0, 3'd1, 8'hA5}, 11, "R4 ch1 write");

    // R5: out-of-range addresses
    send({21'd0, 3'd6, 8'h12}, 11, "R5 addr 6 ignored");
    send({21'd0, 3'd7, 8'h34}, 11, "R5 addr 7 ignored");

    // R9: shutdown flag, codes kept, writes still accepted
    shdn_n = 1'b0;
    wait_clk(6);
    check(shutdown_n === 1'b0, "R9 shutdown asserted", 64'(shutdown_n), 64'd0);
    push_exp("R9 codes kept in shutdown");
    send({21'd0, 3'd2, 8'h66}, 11, "R9 write during shutdown");
    shdn_n = 1'b1;
    wait_clk(6);
    check(shutdown_n === 1'b1, "R9 shutdown released", 64'(shutdown_n), 64'd1);
    push_exp("R9 codes kept after release");

    // R8 / R10: 22 clocks, first frame walks out of the far end
    send({10'd0, 3'd4, 8'hC3, 3'd0, 8'h9E}, 22, "R10 long frame last 11 bits");
    // R10: short frame keeps older bits
    send({28'd0, 4'b1011}, 4, "R10 short frame");

    // R7: preset forces midscale and discards a commit
    preset_n = 1'b0; m_preset_n = 1'b0;
    for (int c = 0; c < NCH; c++) m_lat[c] = 8'h80;
    wait_clk(6);
    push_exp("R7 preset midscale");
    send({21'd0, 3'd2, 8'h22}, 11, "R7 commit under preset");
    preset_n = 1'b1; m_preset_n = 1'b1;
    wait_clk(6);
    push_exp("R7 stays midscale after release");

    // R2: clocks with select high are ignored, then recommit the held frame
    send({21'd0, 3'd4, 8'h5A}, 11, "R2 setup ch4");
    preset_n = 1'b0; m_preset_n = 1'b0;
    for (int c = 0; c < NCH; c++) m_lat[c] = 8'h80;
    wait_clk(6);
    preset_n = 1'b1; m_preset_n = 1'b1;
    wait_clk(6);
    push_exp("R7 preset pulse");
    for (int i = 0; i < 4; i++) sbit(1'(i), 1'b0);
    ser_cs_n = 1'b0;
    wait_clk(6);
    cs_rise("R2 deselected clocks ignored");

    wait_clk(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule